// File: doc/BRIEF.md
# Cascaded Two-Stage Periodic Divider

This block turns a 10 MHz reference, presented as a single-cycle enable on the system clock, into a programmable periodic pulse train. Two 16-bit down-counters are chained. The prescaler counts reference ticks, and each of its terminal counts advances the second counter by one step. The full output period is therefore the product of the two divisors, and the output frequency is 10,000,000 / (n1 × n2).

The host writes each divisor separately. A write of 0 or 1 is refused and the previous value stays. A new divisor waits in a holding register. It becomes active only when its stage reloads, either at its own terminal count or at a realignment. When the synchronous mode input is high, every one-pulse-per-second epoch reloads both stages, so each second starts a fresh output period. When the mode input is low, the chain runs freely and epochs are ignored.

The second stage contains a two-state phase machine with the states PH_HIGH and PH_LOW. A reload (terminal count or epoch) always enters PH_HIGH. A step that brings the second-stage count down to the high/low boundary moves PH_HIGH to PH_LOW. PH_LOW stays in PH_LOW until the next reload. One interrupt-request pulse marks the start of each output period.

Top module: `cascade_period_div`

## Requirements
- R1: After reset, the output is high, the interrupt request is low, and the active divisors are the parameter defaults (n1 = 5, n2 = 4).
- R2: With both divisors fixed, one output period lasts exactly n1 × n2 reference ticks. The interrupt request is high for exactly one clock, in the first cycle of each period.
- R3: Within a period, the output is high for the first floor(n2/2) × n1 reference ticks and low for the rest.
- R4: Clock cycles without a reference tick change neither the counters nor the output, except when an epoch realigns the chain in synchronous mode.
- R5: A divisor write with the value 0 or 1 is ignored, and the previously held value remains in use.
- R6: A new n1 takes effect at the next prescaler terminal count. A new n2 takes effect at the next output-period boundary. Neither shortens or lengthens a count already in progress.
- R7: In synchronous mode (mode input = 1), an epoch pulse reloads both stages from the held divisors. In the following cycle, the output is high and the interrupt request pulses. An epoch takes priority over a reference tick in the same cycle.
- R8: In asynchronous mode (mode input = 0), epoch pulses have no effect on the output or the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle enable per 10 MHz reference tick |
| pps_i | input | 1 | One-cycle epoch pulse, once per second |
| sync_mode_i | input | 1 | 1 = realign on epoch, 0 = free running |
| n1_wr_i | input | 1 | Write strobe for the prescaler divisor |
| n1_val_i | input | 16 | Prescaler divisor value |
| n2_wr_i | input | 1 | Write strobe for the second-stage divisor |
| n2_val_i | input | 16 | Second-stage divisor value |
| per_out_o | output | 1 | Periodic output |
| per_irq_o | output | 1 | Periodic interrupt request, one clock per period |

## Verification
The bench goes after divisor changes that arrive partway through a count. A design that loaded them at once would produce one truncated or stretched period, and the cycle-by-cycle model would catch the early edge. Odd and minimum divisors (n2 = 2, 3, 7 and n1 = 2) test the floor rule for the high phase. An off-by-one there would shift the falling edge by a whole prescaler period. Epochs are sent in free mode, in synchronous mode, in the same cycle as a divisor write, and while the reference enable is idle or toggling. A design that let an epoch leak into free mode, or that gave the tick priority over the epoch, would misplace the period start or drop the interrupt pulse.

// File: rtl/pd_pkg.sv
package pd_pkg;

    // Smallest divisor value a stage accepts.
    localparam int unsigned MIN_DIV = 2;

    // Phase of the second stage within one output period.
    typedef enum logic {
        PH_HIGH = 1'b1,
        PH_LOW  = 1'b0
    } phase_t;

endpackage

// File: rtl/pd_divreg.sv
// Holds the divisor a stage loads at its next reload.
// Writes below the minimum are refused.
module pd_divreg #(
    parameter int unsigned W   = 16,
    parameter int unsigned DEF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] held_o
);
    import pd_pkg::*;

    localparam logic [W-1:0] DEF_V = W'(DEF);
    localparam logic [W-1:0] MIN_V = W'(MIN_DIV);

    logic [W-1:0] held_q;
    logic         accept;

    assign accept = wr_i && (val_i >= MIN_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= DEF_V;
        end else if (accept) begin
            held_q <= val_i;
        end
    end

    assign held_o = held_q;

    // R5: a refused write leaves the held value unchanged
    p_reject_small_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (val_i < MIN_V)) |=> $stable(held_q));

    // R5: the held divisor never drops below the minimum
    p_held_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        held_q >= MIN_V);

endmodule

// File: rtl/pd_stage1.sv
// Prescaler: counts reference ticks down and emits one step per terminal count.
module pd_stage1 #(
    parameter int unsigned W   = 16,
    parameter int unsigned DEF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         realign_i,
    input  logic [W-1:0] div_i,
    output logic         step_o
);
    localparam logic [W-1:0] DEF_V = W'(DEF);
    localparam logic [W-1:0] ONE_V = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic         at_end;

    assign at_end = (cnt_q == ONE_V);

    always_comb begin
        cnt_d = cnt_q;
        if (realign_i) begin
            cnt_d = div_i;
        end else if (tick_i) begin
            cnt_d = at_end ? div_i : (cnt_q - ONE_V);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= DEF_V;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign step_o = tick_i && at_end && !realign_i;

    // R2: the prescaler count never reaches zero
    p_cnt_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);

    // R4: a cycle with no tick and no realignment holds the count
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !realign_i) |=> $stable(cnt_q));

    // R7: a realignment loads the held divisor
    p_realign_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        realign_i |=> (cnt_q == $past(div_i)));

endmodule

// File: rtl/pd_stage2.sv
// Second stage: counts prescaler steps, runs the high/low phase machine and
// raises the interrupt request at each period start.
module pd_stage2 #(
    parameter int unsigned W   = 16,
    parameter int unsigned DEF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         realign_i,
    input  logic [W-1:0] div_i,
    output logic         per_o,
    output logic         irq_o
);
    import pd_pkg::*;

    localparam logic [W-1:0] DEF_V = W'(DEF);
    localparam logic [W-1:0] ONE_V = W'(1);

    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] act_q, act_d;
    logic [W-1:0] low_lim;
    logic         irq_q, irq_d;
    logic         reload;
    phase_t       st_q, st_d;

    // Count values at or below this limit belong to the low phase.
    assign low_lim = act_q - (act_q >> 1);
    assign reload  = realign_i || (step_i && (cnt_q == ONE_V));

    // Counter and active divisor.
    always_comb begin
        cnt_d = cnt_q;
        act_d = act_q;
        irq_d = 1'b0;
        if (reload) begin
            cnt_d = div_i;
            act_d = div_i;
            irq_d = 1'b1;
        end else if (step_i) begin
            cnt_d = cnt_q - ONE_V;
        end
    end

    // Phase machine transitions.
    always_comb begin
        st_d = st_q;
        if (reload) begin
            st_d = PH_HIGH;
        end else begin
            unique case (st_q)
                PH_HIGH: if (step_i && (cnt_d <= low_lim)) st_d = PH_LOW;
                PH_LOW:  st_d = PH_LOW;
                default: st_d = PH_HIGH;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PH_HIGH;
            cnt_q <= DEF_V;
            act_q <= DEF_V;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            act_q <= act_d;
            irq_q <= irq_d;
        end
    end

    // Outputs.
    always_comb begin
        unique case (st_q)
            PH_HIGH: per_o = 1'b1;
            PH_LOW:  per_o = 1'b0;
            default: per_o = 1'b0;
        endcase
        irq_o = irq_q;
    end

    // R7: a realignment starts a fresh high phase with an interrupt request
    p_realign_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        realign_i |=> (per_o && irq_o));

    // R3: every period starts in the high phase
    p_irq_in_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> per_o);

    // R3: the phase never returns to high except through a reload
    p_low_until_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_o && !reload) |=> !per_o);

    // R4: with no step and no realignment, the phase holds
    p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !realign_i) |=> $stable(st_q));

endmodule

// File: rtl/cascade_period_div.sv
module cascade_period_div #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DEF_N1 = 5,
    parameter int unsigned DEF_N2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick_i,
    input  logic             pps_i,
    input  logic             sync_mode_i,
    input  logic             n1_wr_i,
    input  logic [CNT_W-1:0] n1_val_i,
    input  logic             n2_wr_i,
    input  logic [CNT_W-1:0] n2_val_i,
    output logic             per_out_o,
    output logic             per_irq_o
);
    logic [CNT_W-1:0] n1_held;
    logic [CNT_W-1:0] n2_held;
    logic             realign;
    logic             step;

    assign realign = sync_mode_i && pps_i;

    pd_divreg #(.W(CNT_W), .DEF(DEF_N1)) u_n1_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (n1_wr_i),
        .val_i  (n1_val_i),
        .held_o (n1_held)
    );

    pd_divreg #(.W(CNT_W), .DEF(DEF_N2)) u_n2_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (n2_wr_i),
        .val_i  (n2_val_i),
        .held_o (n2_held)
    );

    pd_stage1 #(.W(CNT_W), .DEF(DEF_N1)) u_stage1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (ref_tick_i),
        .realign_i (realign),
        .div_i     (n1_held),
        .step_o    (step)
    );

    pd_stage2 #(.W(CNT_W), .DEF(DEF_N2)) u_stage2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .realign_i (realign),
        .div_i     (n2_held),
        .per_o     (per_out_o),
        .irq_o     (per_irq_o)
    );

    // R8: in free mode an epoch alone, with no tick, changes nothing
    p_free_ignores_pps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode_i && pps_i && !ref_tick_i) |=> ($stable(per_out_o) && !per_irq_o));

    // R2: the interrupt request is a single-cycle pulse unless epochs repeat
    p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (per_irq_o && !realign) |=> !per_irq_o);

endmodule

// File: tb/cascade_period_div_tb_top.sv
module cascade_period_div_tb_top;
    localparam int D1 = 5;
    localparam int D2 = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        pps = 1'b0;
    logic        sync_mode = 1'b0;
    logic        n1_wr = 1'b0;
    logic [15:0] n1_val = '0;
    logic        n2_wr = 1'b0;
    logic [15:0] n2_val = '0;
    logic        per_out;
    logic        per_irq;

    always #2 clk = ~clk;   // 250 MHz

    cascade_period_div dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .pps_i(pps),
        .sync_mode_i(sync_mode), .n1_wr_i(n1_wr), .n1_val_i(n1_val),
        .n2_wr_i(n2_wr), .n2_val_i(n2_val), .per_out_o(per_out), .per_irq_o(per_irq)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";
    bit    cmp_en   = 1'b0;
    int    tick_mode = 0;   // 0 always, 1 alternate, 2 never
    int    cyc = 0;

    // Behavioural model: position within the prescaler and within the period.
    int m_p1, m_p2, m_n1, m_n2, m_s1, m_k;
    bit m_irq;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            m_p1 = D1; m_p2 = D2; m_n1 = D1; m_n2 = D2;
            m_s1 = 0; m_k = 0; m_irq = 0;
        end else begin
            m_irq = 0;
            if (sync_mode && pps) begin
                m_n1 = m_p1; m_n2 = m_p2; m_s1 = 0; m_k = 0; m_irq = 1;
            end else if (ref_tick) begin
                m_s1 = m_s1 + 1;
                if (m_s1 >= m_n1) begin
                    m_s1 = 0;
                    m_n1 = m_p1;
                    m_k  = m_k + 1;
                    if (m_k >= m_n2) begin
                        m_k = 0; m_n2 = m_p2; m_irq = 1;
                    end
                end
            end
            if (n1_wr && n1_val >= 2) m_p1 = int'(n1_val);
            if (n2_wr && n2_val >= 2) m_p2 = int'(n2_val);
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            if (n_fails < 20)
                $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check(cur_req, per_out, (m_k < m_n2 / 2), "per_out");
            check(cur_req, per_irq, m_irq, "per_irq");
        end
    end

    // Reference tick generator.
    always @(posedge clk) begin
        #1;
        case (tick_mode)
            0: ref_tick = 1'b1;
            1: ref_tick = cyc[0];
            default: ref_tick = 1'b0;
        endcase
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr1(input logic [15:0] v);
        @(posedge clk); #1 n1_wr = 1'b1; n1_val = v;
        @(posedge clk); #1 n1_wr = 1'b0;
    endtask

    task automatic wr2(input logic [15:0] v);
        @(posedge clk); #1 n2_wr = 1'b1; n2_val = v;
        @(posedge clk); #1 n2_wr = 1'b0;
    endtask

    task automatic epoch();
        @(posedge clk); #1 pps = 1'b1;
        @(posedge clk); #1 pps = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic held;
        run(3);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", per_out, 1'b1, "reset per_out");
        check("R1", per_irq, 1'b0, "reset per_irq");
        cmp_en = 1'b1;
        cur_req = "R1"; run(60);
        cur_req = "R2"; run(100);

        // R6: divisor changes land in the middle of counts
        cur_req = "R6";
        run(7); wr1(16'd3); run(3); wr2(16'd5); run(200);
        wr2(16'd3); run(4); wr1(16'd4); run(150);

        // R3: odd and minimal second-stage divisors
        cur_req = "R3";
        wr2(16'd7); run(150); wr2(16'd2); run(60);

        // R4: idle and sparse reference ticks
        cur_req = "R4";
        tick_mode = 2; run(2);
        @(negedge clk); held = per_out;
        run(20);
        @(negedge clk); check("R4", per_out, held, "idle hold");
        tick_mode = 1; run(200); tick_mode = 0;

        // R5: refused divisor writes
        cur_req = "R5";
        wr1(16'd0); wr2(16'd1); run(80); wr1(16'd1); wr2(16'd0); run(80);

        // R2: minimum divisors, then a longer prescaler
        cur_req = "R2";
        wr1(16'd2); wr2(16'd2); run(60);
        wr1(16'd300); wr2(16'd7); run(4500);

        // R8: free mode ignores epochs
        cur_req = "R8";
        wr1(16'd4); wr2(16'd6); run(60);
        epoch(); run(13); epoch(); run(40);

        // R7: synchronous realignment
        cur_req = "R7";
        sync_mode = 1'b1;
        run(9); epoch();
        @(negedge clk);
        check("R7", per_irq, 1'b1, "irq after epoch");
        check("R7", per_out, 1'b1, "out after epoch");
        run(31); epoch(); run(17);
        @(posedge clk); #1 pps = 1'b1; n2_val = 16'd3; n2_wr = 1'b1;
        @(posedge clk); #1 pps = 1'b0; n2_wr = 1'b0;
        run(50);
        tick_mode = 2; run(3); epoch(); run(10); tick_mode = 0;
        run(60);

        cmp_en = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule